// File: doc/BRIEF.md
# Generation-Aware Status Word Register

This block holds a 32-bit status word that software writes as a full word and reads back as a full word, in the way a flags-restore operation writes it and a flags-save operation reads it. Most bits are plain storage. Six bit positions take special treatment: 12, 13, 14, 15, 18 and 21. What they accept, and what they return, depends on a build-time generation setting, the current operating mode and the current privilege level. Identification code probes the block by writing patterns into these bits and comparing what comes back, so each generation must give its own readable result.

The parameter `GEN` picks one of four behaviours. 0 is the oldest 16-bit part. 1 is the second 16-bit part. 2 is the early 32-bit part. 3 is the later 32-bit part, which supports the identification instruction. The enclosing core supplies the operating mode (`pmode_i`, 1 means protected) and the two-bit privilege level (`cpl_i`, 0 is most privileged). A write is sampled on a rising clock edge. The read port is combinational from the stored word and the current mode. The block does not update arithmetic flags.

Top module: `flags_reg`

## Requirements
- R1: After an asynchronous reset the stored word is 32'h0000_0002. The read value is therefore 32'h0000_F002 when GEN is 0, and 32'h0000_0002 for every other GEN value in either mode.
- R2: Bit 1 always reads as one, whatever is written to it.
- R3: Every bit other than 1, 12–15, 18 and 21 returns the value written on the rising edge where `we_i` was high. The read shows that value once that edge has passed. When `we_i` is low the stored word does not change.
- R4: With GEN 0, bits 12–15 always read as one, and writes to them have no effect.
- R5: With GEN 1 in real mode (`pmode_i`=0), bits 12–15 read as zero and writes to bits 12–14 are ignored. In protected mode, GEN 1 follows R7 and bit 15 reads as zero.
- R6: With GEN 2 or 3, bit 15 always reads as zero. In real mode, bits 12–14 take every write.
- R7: In protected mode with GEN 1, 2 or 3, bit 14 takes every write. Bits 13:12 take the written value only when `cpl_i` is 0, and otherwise keep their old value.
- R8: Bit 18 can be set and cleared only when GEN is 3. For GEN 0, 1 and 2 it reads as zero.
- R9: Bit 21 can be set and cleared only when GEN is 3. For GEN 0, 1 and 2 it reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Full-word write enable |
| wd_i | input | 32 | Write data |
| pmode_i | input | 1 | 1 = protected mode, 0 = real mode |
| cpl_i | input | 2 | Current privilege level |
| rd_o | output | 32 | Read value |

## Verification
The bench builds four instances side by side, one for each value of `GEN` from 0 to 3, and drives all four from the same inputs. Each instance has its own model in the bench. Every write is repeated for each combination of mode and privilege level, with patterns that set, clear and alternate the special bits. After each write the bench also reads the word back in the other mode. This brings within reach the mode-dependent read on GEN 1, the privilege gating of bits 13:12, and the fact that bits 18 and 21 can change only on the latest generation.

// File: rtl/flags_pkg.sv
package flags_pkg;
  localparam int FLAGS_W    = 32;
  localparam int B_ONE      = 1;
  localparam int B_PRIV_LO  = 12;
  localparam int B_PRIV_HI  = 13;
  localparam int B_TASK     = 14;
  localparam int B_TOP      = 15;
  localparam int B_ALNCHK   = 18;
  localparam int B_IDPROBE  = 21;

  localparam logic [FLAGS_W-1:0] RESET_VAL = 32'h0000_0002;

  // bits with no special rule
  localparam logic [FLAGS_W-1:0] PLAIN_MASK =
    ~((32'h1 << B_ONE) | (32'hF << B_PRIV_LO) | (32'h1 << B_ALNCHK) | (32'h1 << B_IDPROBE));

  typedef enum logic [1:0] {
    GEN_OLD16   = 2'd0,
    GEN_NEW16   = 2'd1,
    GEN_EARLY32 = 2'd2,
    GEN_LATE32  = 2'd3
  } gen_e;
endpackage

// File: rtl/flags_wmask.sv
module flags_wmask
  import flags_pkg::*;
#(
  parameter int GEN = 3
) (
  input  logic               pmode_i,
  input  logic [1:0]         cpl_i,
  output logic [FLAGS_W-1:0] mask_o
);
  localparam bit HAS_PRIV  = (GEN >= int'(GEN_NEW16));
  localparam bit FREE_REAL = (GEN >= int'(GEN_EARLY32));
  localparam bit HAS_ID    = (GEN == int'(GEN_LATE32));

  logic open_upper;
  assign open_upper = HAS_PRIV && (FREE_REAL || pmode_i);

  always_comb begin
    mask_o = PLAIN_MASK;
    if (open_upper) begin
      mask_o[B_TASK] = 1'b1;
      if (!pmode_i || cpl_i == 2'd0) begin
        mask_o[B_PRIV_HI] = 1'b1;
        mask_o[B_PRIV_LO] = 1'b1;
      end
    end
    if (HAS_ID) begin
      mask_o[B_ALNCHK]  = 1'b1;
      mask_o[B_IDPROBE] = 1'b1;
    end
  end
endmodule

// File: rtl/flags_rshape.sv
module flags_rshape
  import flags_pkg::*;
#(
  parameter int GEN = 3
) (
  input  logic [FLAGS_W-1:0] state_i,
  input  logic               pmode_i,
  output logic [FLAGS_W-1:0] rd_o
);
  logic [FLAGS_W-1:0] keep;
  logic [FLAGS_W-1:0] force1;

  generate
    if (GEN == int'(GEN_OLD16)) begin : g_old16
      logic unused_pmode;
      assign unused_pmode = pmode_i;
      assign keep   = ~((32'hF << B_PRIV_LO) | (32'h1 << B_ALNCHK) | (32'h1 << B_IDPROBE));
      assign force1 = (32'hF << B_PRIV_LO) | (32'h1 << B_ONE);
    end else if (GEN == int'(GEN_NEW16)) begin : g_new16
      // real mode hides the whole upper nibble
      assign keep   = pmode_i
                    ? ~((32'h1 << B_TOP) | (32'h1 << B_ALNCHK) | (32'h1 << B_IDPROBE))
                    : ~((32'hF << B_PRIV_LO) | (32'h1 << B_ALNCHK) | (32'h1 << B_IDPROBE));
      assign force1 = 32'h1 << B_ONE;
    end else if (GEN == int'(GEN_EARLY32)) begin : g_early32
      logic unused_pmode;
      assign unused_pmode = pmode_i;
      assign keep   = ~((32'h1 << B_TOP) | (32'h1 << B_ALNCHK) | (32'h1 << B_IDPROBE));
      assign force1 = 32'h1 << B_ONE;
    end else begin : g_late32
      logic unused_pmode;
      assign unused_pmode = pmode_i;
      assign keep   = ~(32'h1 << B_TOP);
      assign force1 = 32'h1 << B_ONE;
    end
  endgenerate

  assign rd_o = (state_i & keep) | force1;
endmodule

// File: rtl/flags_reg.sv
module flags_reg
  import flags_pkg::*;
#(
  parameter int GEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [31:0]        wd_i,
  input  logic               pmode_i,
  input  logic [1:0]         cpl_i,
  output logic [31:0]        rd_o
);
  logic [FLAGS_W-1:0] flags_q;
  logic [FLAGS_W-1:0] wmask;

  flags_wmask #(.GEN(GEN)) u_wmask (
    .pmode_i (pmode_i),
    .cpl_i   (cpl_i),
    .mask_o  (wmask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= RESET_VAL;
    else if (we_i)  flags_q <= (wd_i & wmask) | (flags_q & ~wmask);
  end

  flags_rshape #(.GEN(GEN)) u_rshape (
    .state_i (flags_q),
    .pmode_i (pmode_i),
    .rd_o    (rd_o)
  );

  AST_BIT1_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o[B_ONE]) else $error("bit1 clear"); // R2
  AST_PLAIN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((rd_o & PLAIN_MASK) == ($past(wd_i) & PLAIN_MASK))) else $error("plain bits"); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_q)) else $error("state moved"); // R3
  AST_OLD_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN == 0) |-> (rd_o[15:12] == 4'hF)) else $error("old nibble"); // R4
  AST_NEW16_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN == 1 && !pmode_i) |-> (rd_o[15:12] == 4'h0)) else $error("new16 real"); // R5
  AST_TOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN >= 1 && (GEN >= 2 || pmode_i)) |-> !rd_o[B_TOP]) else $error("bit15 set"); // R6
  AST_PRIV_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN >= 2 && we_i && pmode_i && cpl_i != 2'd0) |=>
      (rd_o[13:12] == $past(rd_o[13:12]))) else $error("priv field moved"); // R7
  AST_ALN_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN < 3) |-> !rd_o[B_ALNCHK]) else $error("bit18 set"); // R8
  AST_ID_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GEN < 3) |-> !rd_o[B_IDPROBE]) else $error("bit21 set"); // R9
endmodule

// File: tb/flags_reg_tb_top.sv
`timescale 1ns/1ps
module flags_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] wd_i = '0;
  logic        pmode_i = 1'b0;
  logic [1:0]  cpl_i = '0;
  logic [31:0] rd [4];
  logic [31:0] mdl [4];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  for (genvar g = 0; g < 4; g++) begin : gen_dut
    flags_reg #(.GEN(g)) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wd_i(wd_i),
      .pmode_i(pmode_i), .cpl_i(cpl_i), .rd_o(rd[g])
    );
  end

  // expected stored word after a write, bit by bit from R2..R9
  function automatic logic [31:0] nxt(int g, logic [31:0] old, logic [31:0] wd,
                                      logic pm, logic [1:0] cpl);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i == 1) r[i] = 1'b1;
      else if (i >= 12 && i <= 15) begin
        if (g == 0 || (g == 1 && !pm) || i == 15) r[i] = old[i];
        else if (i == 14) r[i] = wd[i];
        else r[i] = (!pm || cpl == 2'd0) ? wd[i] : old[i];
      end
      else if (i == 18 || i == 21) r[i] = (g == 3) ? wd[i] : old[i];
      else r[i] = wd[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] shown(int g, logic [31:0] s, logic pm);
    logic [31:0] r = s;
    r[1] = 1'b1;
    if (g == 0) r[15:12] = 4'hF;
    else if (g == 1 && !pm) r[15:12] = 4'h0;
    else r[15] = 1'b0;
    if (g < 3) begin r[18] = 1'b0; r[21] = 1'b0; end
    return r;
  endfunction

  function automatic string req_of(logic [31:0] d, int g, logic pm);
    if (d[1]) return "R2";
    if (d[15:12] != 0 && g == 0) return "R4";
    if (d[15:12] != 0 && g == 1) return pm ? "R7" : "R5";
    if (d[15]) return "R6";
    if (d[14:12] != 0) return pm ? "R7" : "R6";
    if (d[18]) return "R8";
    if (d[21]) return "R9";
    return "R3";
  endfunction

  task automatic check_all(string tag);
    for (int g = 0; g < 4; g++) begin
      logic [31:0] e = shown(g, mdl[g], pmode_i);
      checks++;
      if (rd[g] !== e) begin
        fails++;
        $display("FAIL %s gen=%0d pm=%0b cpl=%0d actual=%h expected=%h (%s)",
                 req_of(rd[g] ^ e, g, pmode_i), g, pmode_i, cpl_i, rd[g], e, tag);
      end
    end
  endtask

  task automatic do_write(logic [31:0] wd, logic pm, logic [1:0] cpl);
    @(negedge clk_i);
    we_i = 1'b1; wd_i = wd; pmode_i = pm; cpl_i = cpl;
    @(negedge clk_i);
    we_i = 1'b0;
    for (int g = 0; g < 4; g++) mdl[g] = nxt(g, mdl[g], wd, pm, cpl);
    check_all("write");
    pmode_i = ~pm; // read back in the other mode, R5
    #1 check_all("mode flip");
    pmode_i = pm;
  endtask

  initial begin
    logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5,
                              32'h5A5A_5A5A, 32'h0024_7000, 32'h0000_3000};
    for (int g = 0; g < 4; g++) mdl[g] = 32'h0000_0002;
    repeat (3) @(negedge clk_i);
    check_all("reset R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("reset R1");
    // sweep R3..R9 over mode, privilege and patterns
    for (int pm = 0; pm < 2; pm++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 6; p++)
          do_write(pats[p], pm[0], c[1:0]);
    // R3 idle: data toggles with enable low
    do_write(32'h0024_7FF0, 1'b0, 2'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      wd_i = ~wd_i; cpl_i = k[1:0]; pmode_i = k[0];
      @(negedge clk_i);
      check_all("idle R3");
    end
    // R7 privilege gate: set field at cpl0, try clear at cpl3
    do_write(32'h0000_3000, 1'b1, 2'd0);
    do_write(32'h0000_0000, 1'b1, 2'd3);
    do_write(32'h0000_0000, 1'b1, 2'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule